// File: doc/BRIEF.md
# Linked-List Stream Packet Sequencer

This block steps through a small table of 32-bit descriptors and turns each usable descriptor into an ordered series of commands for a downstream packet formatter. A descriptor can request a line-start short packet, a long-packet header, a payload of a given number of 16-bit samples, and a line-end short packet. Software loads descriptors through a simple write port while the block is idle, then pulses `start`. The block walks the table from slot 0 upward. The walk stops at the first descriptor whose valid bit is clear, or after the last slot, and `done` then pulses for one cycle.

Samples arrive on a valid/ready input stream and leave on the command stream. Both streams follow the same back-pressure rule. A transfer happens only in a cycle where valid and ready are both high. A producer holding valid high keeps its payload stable until that transfer. During the payload phase the input `smp_ready` follows the output's `ev_ready`, so the formatter throttles the sample source directly. Short-packet and header commands are held on the output until the formatter accepts them. A descriptor can also ask the block to wait for a packet-sent acknowledge before it moves on to the next slot.

Descriptor fields (bit positions): valid 0, line-end 1, line-start 2, virtual channel 4:3, sample width 6:5, sample count 22:9, wait-for-acknowledge 26, header 27. All other bits are ignored. Command codes on `ev_kind`: 1 line start, 2 header, 3 sample, 4 line end, 0 none.

Top module: `llseq_top`

## Requirements
- R1: After reset every table slot reads as invalid, `busy`, `done`, `ev_valid` and `smp_ready` are low, and a start on the untouched table produces a `done` pulse with no commands.
- R2: A slot whose bit 0 is clear ends the walk: neither it nor any later slot produces commands, and `done` pulses.
- R3: When bit 2 of a slot is set, a command of kind 1 (line start) is issued before anything else of that slot.
- R4: When bit 27 is set, a command of kind 2 (header) is issued after any line start and before the payload, with `ev_vc` equal to bits 4:3 and `ev_len` equal to bits 22:9; when bit 27 is clear no header is issued and the payload continues the previous packet.
- R5: The payload phase transfers exactly the count in bits 22:9 of samples, each issued as kind 3 with `ev_data` equal to the accepted input sample and `ev_fmt` equal to bits 6:5 (00 16-bit, 01 14-bit, 10 12-bit). `smp_ready` is high only during the payload, and only while `ev_ready` is high.
- R6: When bit 1 is set, a command of kind 4 (line end) is issued after the payload.
- R7: A count of zero skips the payload, while any requested line start, header and line end are still issued.
- R8: When bit 26 is set, once the slot's last command is accepted the block issues nothing more and holds `done` low until `pkt_sent` is seen high.
- R9: Slots are visited in ascending order from slot 0. After the last slot the walk ends with a single-cycle `done` pulse.
- R10: `busy` is high from the cycle after an accepted start until the walk ends. Table writes are ignored while `busy` is high. A write presented in the same cycle as the accepted start takes effect and is used by the walk.
- R11: A short-packet or header command stalled by a low `ev_ready` stays valid with the same `ev_kind` until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 2 | Table slot index for the write |
| cfg_wdata | input | 32 | Descriptor word to write |
| start | input | 1 | Begin a walk (ignored while busy) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| smp_valid | input | 1 | Input sample valid |
| smp_ready | output | 1 | Input sample accepted when high with valid |
| smp_data | input | 16 | Input sample |
| ev_valid | output | 1 | Command valid |
| ev_ready | input | 1 | Formatter accepts the command |
| ev_kind | output | 3 | Command code |
| ev_vc | output | 2 | Virtual channel of the current slot |
| ev_fmt | output | 2 | Sample width code of the current slot |
| ev_len | output | 14 | Sample count of the current slot |
| ev_data | output | 16 | Sample value for kind 3, zero otherwise |
| pkt_sent | input | 1 | Packet-sent acknowledge |

## Verification
Two functions can act on the same clock edge: a table write and the accepted start of a walk. The bench drives `start` together with a write to slot 0 on an otherwise empty table. In the very next cycle it writes slot 1. The walk must show the slot-0 write, must ignore the slot-1 write, and must end after slot 0. The command stream is compared with a bench model throughout. That model also covers random tables, random back-pressure on both streams and random acknowledge timing.

// File: rtl/llseq_pkg.sv
package llseq_pkg;

  localparam int WORD_W = 32;
  localparam int SIZE_W = 14;
  localparam int SMP_W  = 16;

  localparam logic [2:0] EV_NONE = 3'd0;
  localparam logic [2:0] EV_LS   = 3'd1;
  localparam logic [2:0] EV_HDR  = 3'd2;
  localparam logic [2:0] EV_SMP  = 3'd3;
  localparam logic [2:0] EV_LE   = 3'd4;

  typedef struct packed {
    logic              hdr;
    logic              wait_ack;
    logic [SIZE_W-1:0] size;
    logic [1:0]        fmt;
    logic [1:0]        vc;
    logic              ls;
    logic              le;
  } entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LS, S_HDR, S_PAY, S_LE, S_WACK, S_ADV
  } state_t;

  // Next phase of a descriptor after the phase 'from' has completed.
  function automatic state_t next_phase(state_t from, entry_t e);
    if (from == S_FETCH && e.ls) return S_LS;
    if ((from == S_FETCH || from == S_LS) && e.hdr) return S_HDR;
    if ((from == S_FETCH || from == S_LS || from == S_HDR) && e.size != '0) return S_PAY;
    if (from != S_LE && e.le) return S_LE;
    return e.wait_ack ? S_WACK : S_ADV;
  endfunction

endpackage

// File: rtl/llseq_table.sv
module llseq_table import llseq_pkg::*; #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [NUM_ENTRIES-1:0][WORD_W-1:0] slots_q;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots_q[g] <= '0;
      end else if (wr_en && !busy_i && wr_idx == IDX_W'(g)) begin
        slots_q[g] <= wr_word;
      end
    end
  end

  assign rd_word = slots_q[rd_idx];

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(slots_q)); // R10

endmodule

// File: rtl/llseq_decode.sv
module llseq_decode import llseq_pkg::*; (
  input  logic [WORD_W-1:0] raw,
  output logic              valid,
  output entry_t            ent
);

  logic [8:0] unused_bits;

  always_comb begin
    valid        = raw[0];
    ent.le       = raw[1];
    ent.ls       = raw[2];
    ent.vc       = raw[4:3];
    ent.fmt      = raw[6:5];
    ent.size     = raw[22:9];
    ent.wait_ack = raw[26];
    ent.hdr      = raw[27];
  end

  assign unused_bits = {raw[31:28], raw[25:23], raw[8:7]};

endmodule

// File: rtl/llseq_fsm.sv
module llseq_fsm import llseq_pkg::*; #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fetch_valid,
  input  entry_t            fetch_ent,
  output logic [IDX_W-1:0]  idx,
  output logic              busy,
  output logic              done,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [2:0]        ev_kind,
  output logic [1:0]        ev_vc,
  output logic [1:0]        ev_fmt,
  output logic [SIZE_W-1:0] ev_len,
  output logic [SMP_W-1:0]  ev_data,
  input  logic              pkt_sent
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  state_t            state_q, state_d, go;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  entry_t            ent_q, ent_d;
  logic              done_q, done_d;
  logic              take;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    ent_d     = ent_q;
    done_d    = 1'b0;
    take      = 1'b0;
    go        = S_ADV;
    ev_valid  = 1'b0;
    ev_kind   = EV_NONE;
    smp_ready = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start) begin
          idx_d   = '0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        if (!fetch_valid) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          ent_d = fetch_ent;
          cnt_d = '0;
          take  = 1'b1;
          go    = next_phase(S_FETCH, fetch_ent);
        end
      end
      S_LS: begin
        ev_valid = 1'b1;
        ev_kind  = EV_LS;
        if (ev_ready) begin
          take = 1'b1;
          go   = next_phase(S_LS, ent_q);
        end
      end
      S_HDR: begin
        ev_valid = 1'b1;
        ev_kind  = EV_HDR;
        if (ev_ready) begin
          take = 1'b1;
          go   = next_phase(S_HDR, ent_q);
        end
      end
      S_PAY: begin
        ev_valid  = smp_valid;
        ev_kind   = EV_SMP;
        smp_ready = ev_ready;
        if (smp_valid && ev_ready) begin
          if (cnt_q == ent_q.size - SIZE_W'(1)) begin
            take = 1'b1;
            go   = next_phase(S_PAY, ent_q);
          end else begin
            cnt_d = cnt_q + SIZE_W'(1);
          end
        end
      end
      S_LE: begin
        ev_valid = 1'b1;
        ev_kind  = EV_LE;
        if (ev_ready) begin
          take = 1'b1;
          go   = next_phase(S_LE, ent_q);
        end
      end
      S_WACK: begin
        if (pkt_sent) begin
          take = 1'b1;
          go   = S_ADV;
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (take) begin
      if (go != S_ADV) begin
        state_d = go;
      end else if (idx_q == LAST_IDX) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end else begin
        idx_d   = idx_q + IDX_W'(1);
        state_d = S_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      ent_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      ent_q   <= ent_d;
      done_q  <= done_d;
    end
  end

  assign idx     = idx_q;
  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign ev_vc   = ent_q.vc;
  assign ev_fmt  = ent_q.fmt;
  assign ev_len  = ent_q.size;
  assign ev_data = (state_q == S_PAY) ? smp_data : '0;

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WACK && !pkt_sent) |=> (state_q == S_WACK && !done_q)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready && ev_kind != EV_SMP) |=> (ev_valid && $stable(ev_kind))); // R11
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PAY) |-> (cnt_q < ent_q.size)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ev_valid && !smp_ready)); // R5

endmodule

// File: rtl/llseq_top.sv
module llseq_top import llseq_pkg::*; #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [2:0]        ev_kind,
  output logic [1:0]        ev_vc,
  output logic [1:0]        ev_fmt,
  output logic [SIZE_W-1:0] ev_len,
  output logic [SMP_W-1:0]  ev_data,
  input  logic              pkt_sent
);

  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              fetch_valid;
  entry_t            fetch_ent;

  llseq_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_addr),
    .wr_word (cfg_wdata),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  llseq_decode u_decode (
    .raw   (rd_word),
    .valid (fetch_valid),
    .ent   (fetch_ent)
  );

  llseq_fsm #(.NUM_ENTRIES(NUM_ENTRIES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fetch_valid (fetch_valid),
    .fetch_ent   (fetch_ent),
    .idx         (rd_idx),
    .busy        (busy),
    .done        (done),
    .smp_valid   (smp_valid),
    .smp_ready   (smp_ready),
    .smp_data    (smp_data),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .ev_kind     (ev_kind),
    .ev_vc       (ev_vc),
    .ev_fmt      (ev_fmt),
    .ev_len      (ev_len),
    .ev_data     (ev_data),
    .pkt_sent    (pkt_sent)
  );

endmodule

// File: tb/llseq_top_tb.sv
module llseq_top_tb;

  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = 16'h1000;
  logic        ev_valid;
  logic        ev_ready = 1'b0;
  logic [2:0]  ev_kind;
  logic [1:0]  ev_vc, ev_fmt;
  logic [13:0] ev_len;
  logic [15:0] ev_data;
  logic        pkt_sent = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int gcyc  = 0;
  logic [31:0] tb_tab [NE];
  logic [39:0] exp_q [$];
  int exp_pos;

  always #2 clk = ~clk;

  llseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .busy(busy), .done(done), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
    .ev_vc(ev_vc), .ev_fmt(ev_fmt), .ev_len(ev_len), .ev_data(ev_data), .pkt_sent(pkt_sent)
  );

  always @(posedge clk) begin
    gcyc <= gcyc + 1;
    if (gcyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected under 150000", gcyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [39:0] mk(logic [2:0] k, logic [1:0] vc, logic [1:0] fmt,
                                     logic [13:0] len, logic [15:0] d);
    return {3'b0, k, vc, fmt, len, d};
  endfunction

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  // Model: expected command stream from the bench copy of the table.
  task automatic build_expected();
    logic [15:0] d;
    d = smp_data;
    exp_q.delete();
    for (int i = 0; i < NE; i++) begin
      logic [31:0] w;
      w = tb_tab[i];
      if (!w[0]) break;
      if (w[2]) exp_q.push_back(mk(3'd1, 2'd0, 2'd0, 14'd0, 16'd0));
      if (w[27]) exp_q.push_back(mk(3'd2, w[4:3], 2'd0, w[22:9], 16'd0));
      for (int s = 0; s < int'(w[22:9]); s++) begin
        exp_q.push_back(mk(3'd3, 2'd0, w[6:5], 14'd0, d));
        d = d + 16'd1;
      end
      if (w[1]) exp_q.push_back(mk(3'd4, 2'd0, 2'd0, 14'd0, 16'd0));
    end
  endtask

  task automatic wr(int idx, logic [31:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 2'(idx); cfg_wdata = w;
    tb_tab[idx] = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ent(bit v, bit ls, bit hdr, bit le, bit wt,
                                      logic [1:0] vc, logic [1:0] fmt, int size);
    logic [31:0] w;
    w = '0;
    w[0] = v; w[1] = le; w[2] = ls; w[4:3] = vc; w[6:5] = fmt;
    w[22:9] = 14'(size); w[26] = wt; w[27] = hdr;
    return w;
  endfunction

  // mode 0 random, 1 held acknowledge, 2 stalled formatter, 3 write while busy
  task automatic run_walk(int mode);
    int cyc;
    bit fin, hs_smp;
    logic [39:0] act;
    cyc = 0; fin = 0; hs_smp = 0; exp_pos = 0;
    while (!fin) begin
      @(posedge clk); #1;
      cyc++;
      if (hs_smp) smp_data = smp_data + 16'd1;
      start = 1'b0;
      cfg_we = (mode == 3 && cyc == 1);
      cfg_addr = 2'd1;
      cfg_wdata = ent(1, 1, 0, 1, 0, 2'd0, 2'd0, 0);
      case (mode)
        1: begin ev_ready = 1'b1; smp_valid = 1'b1; pkt_sent = (cyc >= 20); end
        2: begin ev_ready = (cyc >= 6); smp_valid = 1'b1; pkt_sent = 1'b1; end
        default: begin
          ev_ready  = ($urandom % 4) != 0;
          smp_valid = ($urandom % 3) != 0;
          pkt_sent  = ($urandom % 3) == 0;
        end
      endcase
      #1;
      if (mode == 3 && cyc == 1)
        check(busy === 1'b1, "R10 busy after start", {39'd0, busy}, 40'd1);
      if (mode == 2 && cyc >= 2 && cyc <= 5)
        check(ev_valid === 1'b1 && ev_kind === 3'd1, "R11 stalled command held",
              {36'd0, ev_valid, ev_kind}, {36'd0, 1'b1, 3'd1});
      if (ev_valid && !ev_ready && ev_kind == 3'd3)
        ; // payload stall, nothing to log
      hs_smp = smp_valid && smp_ready;
      if (smp_ready && !ev_ready)
        check(1'b0, "R5 ready without downstream ready", {39'd0, smp_ready}, 40'd0);
      if (ev_valid && ev_ready) begin
        act = mk(ev_kind, (ev_kind == 3'd2) ? ev_vc : 2'd0, (ev_kind == 3'd3) ? ev_fmt : 2'd0,
                 (ev_kind == 3'd2) ? ev_len : 14'd0, (ev_kind == 3'd3) ? ev_data : 16'd0);
        if (exp_pos < exp_q.size())
          check(act === exp_q[exp_pos], tag_of(exp_q[exp_pos][34:32]), act, exp_q[exp_pos]);
        else
          check(1'b0, "R2 extra command", act, 40'd0);
        if (mode == 1 && cyc < 20 && ev_kind == 3'd1)
          check(1'b0, "R8 advanced before acknowledge", {37'd0, ev_kind}, 40'd0);
        exp_pos++;
      end
      if (done) begin
        fin = 1;
        if (mode == 1)
          check(cyc >= 20, "R8 done before acknowledge", 40'(cyc), 40'd20);
      end
      if (cyc > 3000) begin
        check(1'b0, "R9 walk did not finish", 40'(cyc), 40'd0);
        fin = 1;
      end
    end
    check(exp_pos == exp_q.size(), "R9 command count", 40'(exp_pos), 40'(exp_q.size()));
    ev_ready = 1'b0; smp_valid = 1'b0; pkt_sent = 1'b0;
    @(posedge clk); #1;
    check(done === 1'b0 && busy === 1'b0, "R9 single done pulse",
          {38'd0, done, busy}, 40'd0);
  endtask

  task automatic go_walk(int mode);
    build_expected();
    start = 1'b1;
    run_walk(mode);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NE; i++) tb_tab[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0 && ev_valid === 1'b0 && smp_ready === 1'b0,
          "R1 reset outputs", {36'd0, busy, done, ev_valid, smp_ready}, 40'd0);
    go_walk(0); // R1 empty table: done, no commands

    // R9: all slots valid, ascending order, header on/off mixed
    wr(0, ent(1, 1, 1, 0, 0, 2'd2, 2'd0, 3));
    wr(1, ent(1, 0, 0, 1, 0, 2'd1, 2'd1, 2));
    wr(2, ent(1, 1, 1, 1, 0, 2'd3, 2'd2, 1));
    wr(3, ent(1, 0, 1, 0, 0, 2'd0, 2'd0, 4));
    go_walk(0);

    // R2: invalid slot 1 stops the walk even with other bits set
    wr(1, ent(0, 1, 1, 1, 0, 2'd3, 2'd1, 5));
    go_walk(0);

    // R7: zero count still wraps short packets and header
    wr(0, ent(1, 1, 1, 1, 0, 2'd1, 2'd2, 0));
    go_walk(0);

    // R8: held acknowledge
    wr(0, ent(1, 0, 0, 1, 1, 2'd0, 2'd0, 0));
    wr(1, ent(1, 1, 0, 0, 0, 2'd0, 2'd0, 0));
    wr(2, '0);
    go_walk(1);

    // R11: stalled line start
    wr(0, ent(1, 1, 0, 0, 0, 2'd0, 2'd0, 0));
    wr(1, '0);
    go_walk(2);

    // R10: write with start accepted, write one cycle later ignored
    for (int i = 0; i < NE; i++) wr(i, '0);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 2'd0;
    cfg_wdata = ent(1, 1, 1, 0, 0, 2'd2, 2'd1, 2);
    tb_tab[0] = cfg_wdata;
    go_walk(3);

    // Random tables
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < NE; i++) begin
        logic [31:0] w;
        w = $urandom;
        w[0] = ($urandom % 10) != 0;
        w[22:9] = 14'($urandom % 6);
        wr(i, w);
      end
      go_walk(0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule